// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Unit

This block holds the transmit and receive data queues of an SPI controller and produces the interrupt requests that software uses to keep them serviced. The CPU pushes words into the transmit queue and pops words from the receive queue through a shared data register. The serial engine drains the transmit queue over a valid/ready handshake and fills the receive queue with a valid-only strobe. Both fill levels are visible at all times. Two programmable thresholds turn those levels into a "transmit queue running low" request and a "receive queue has data" request.

Misuse of the data register is recorded in three sticky error flags: a CPU write into a full transmit queue, an engine push into a full receive queue, and a CPU read from an empty receive queue. The five sources form a raw status vector. A mask selects which of them reach the masked status, and the single interrupt line is the OR of the masked status. Threshold registers keep only values below the queue depth, so software can find the depth by writing rising values and reading them back. Dropping the enable flushes both queues and clears the error flags.

Back-pressure rules: the engine takes a transmit word only in a cycle where `tx_out_valid` and `tx_out_ready` are both high. The engine's receive strobe and the CPU strobes have no ready signal. A strobe that cannot be honoured drops its word and raises the matching error flag.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: `tx_level` and `rx_level` give the number of stored entries, from 0 to DEPTH. A transmit entry is added by an accepted CPU write and removed by an engine handshake. A receive entry is added by an accepted engine push and removed by a CPU read.
- R2: Both queues are first-in first-out. `tx_out_data` shows the oldest transmit word and `cpu_rdata` shows the oldest receive word whenever the queue holds at least one entry.
- R3: Status bit 0 (transmit low) is 1 while enabled and `tx_level` is less than or equal to the transmit threshold.
- R4: Status bit 4 (receive ready) is 1 while enabled and `rx_level` is greater than the receive threshold, so a threshold of N-1 fires once N entries are held.
- R5: A CPU write while `tx_level` equals DEPTH sets status bit 1 (transmit overflow) from the next cycle. The word is dropped, even if the engine takes a word in the same cycle.
- R6: An engine push while `rx_level` equals DEPTH sets status bit 3 (receive overflow) from the next cycle, and the word is dropped.
- R7: A CPU read while `rx_level` is 0 sets status bit 2 (receive underflow) from the next cycle.
- R8: Bits 1, 2 and 3 hold until a `sts_clr` strobe or a disable. An error event in the same cycle as `sts_clr` leaves its bit set.
- R9: `masked_status` equals `raw_status` AND `mask_q`, and `irq` is the OR of `masked_status`. The mask resets to zero, so every source is silenced after reset.
- R10: A threshold write stores the value only if it is below DEPTH. Otherwise the previous value is kept. Both thresholds reset to 0.
- R11: While `en` is low, `raw_status` reads zero, all strobes are ignored, and at each clock both queues are emptied and bits 1 to 3 are cleared. Thresholds and mask are kept.
- R12: `tx_out_valid` is high exactly when `tx_level` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low flushes the queues and clears the error flags |
| cpu_wr | input | 1 | CPU write strobe to the data register (transmit push) |
| cpu_wdata | input | WIDTH | CPU write data |
| cpu_rd | input | 1 | CPU read strobe from the data register (receive pop) |
| cpu_rdata | output | WIDTH | Oldest receive word |
| tx_thr_we | input | 1 | Transmit threshold write strobe |
| rx_thr_we | input | 1 | Receive threshold write strobe |
| thr_wdata | input | THR_W | Threshold write value |
| tx_thr | output | THR_W | Transmit threshold readback |
| rx_thr | output | THR_W | Receive threshold readback |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | Mask write value |
| mask_q | output | 5 | Mask readback |
| sts_clr | input | 1 | Clears the sticky error flags |
| tx_out_valid | output | 1 | Transmit queue holds a word for the engine |
| tx_out_ready | input | 1 | Engine takes the offered word |
| tx_out_data | output | WIDTH | Word offered to the engine |
| rx_in_valid | input | 1 | Engine pushes a received word |
| rx_in_data | input | WIDTH | Received word |
| tx_level | output | $clog2(DEPTH+1) | Transmit fill level |
| rx_level | output | $clog2(DEPTH+1) | Receive fill level |
| raw_status | output | 5 | Unmasked interrupt sources |
| masked_status | output | 5 | Sources after the mask |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach from the ports are the coincident ones. Examples are a CPU write into a full transmit queue in the same cycle the engine takes a word, a clear strobe in the same cycle as a new underflow, and a disable while words and error flags are pending. Each of these is driven once by a directed sequence. A long random phase then follows, with strobes of uneven density, occasional disables and threshold writes that straddle the depth. A behavioural queue model is compared against every output on every clock throughout.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int ST_TXEI = 0;
  localparam int ST_TXOI = 1;
  localparam int ST_RXUI = 2;
  localparam int ST_RXOI = 3;
  localparam int ST_RXFI = 4;
  localparam int ST_W    = 5;

  typedef logic [ST_W-1:0] irq_vec_t;

  localparam irq_vec_t STICKY_BITS =
    irq_vec_t'((1 << ST_TXOI) | (1 << ST_RXUI) | (1 << ST_RXOI));
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == FULLC);
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
    end else if (flush) begin
      wp <= '0;
    end else if (do_push) begin
      wp <= (wp == LAST) ? '0 : wp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0;
    end else if (flush) begin
      rp <= '0;
    end else if (do_pop) begin
      rp <= (rp == LAST) ? '0 : rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else begin
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wp] <= push_data;
    end
  end
endmodule

// File: rtl/sfi_thresh.sv
module sfi_thresh #(
  parameter int DEPTH = 8,
  parameter int IN_W  = 8,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IN_W-1:0] wdata,
  output logic [IN_W-1:0] value
);
  logic [TW-1:0] q;
  logic          fits;

  // values at or above the depth are refused, which makes the depth probeable
  assign fits  = (32'(wdata) < 32'(DEPTH));
  assign value = IN_W'(q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we && fits) begin
      q <= wdata[TW-1:0];
    end
  end
endmodule

// File: rtl/sfi_irq_ctrl.sv
module sfi_irq_ctrl
  import sfi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     clr,
  input  logic     txo_evt,
  input  logic     rxu_evt,
  input  logic     rxo_evt,
  input  logic     txe_lvl,
  input  logic     rxf_lvl,
  input  logic     mask_we,
  input  irq_vec_t mask_wdata,
  output irq_vec_t mask_q,
  output irq_vec_t raw,
  output irq_vec_t masked,
  output logic     irq
);
  irq_vec_t evt, sticky_q, lvl;

  always_comb begin
    evt          = '0;
    evt[ST_TXOI] = txo_evt;
    evt[ST_RXUI] = rxu_evt;
    evt[ST_RXOI] = rxo_evt;
    lvl          = '0;
    lvl[ST_TXEI] = txe_lvl;
    lvl[ST_RXFI] = rxf_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else if (!en) begin
      sticky_q <= '0;
    end else begin
      sticky_q <= ((clr ? '0 : sticky_q) | evt) & STICKY_BITS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  assign raw    = en ? (sticky_q | lvl) : '0;
  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import sfi_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int THR_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpu_wr,
  input  logic [WIDTH-1:0] cpu_wdata,
  input  logic             cpu_rd,
  output logic [WIDTH-1:0] cpu_rdata,
  input  logic             tx_thr_we,
  input  logic             rx_thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  output logic [THR_W-1:0] tx_thr,
  output logic [THR_W-1:0] rx_thr,
  input  logic             mask_we,
  input  logic [ST_W-1:0]  mask_wdata,
  output logic [ST_W-1:0]  mask_q,
  input  logic             sts_clr,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [WIDTH-1:0] tx_out_data,
  input  logic             rx_in_valid,
  input  logic [WIDTH-1:0] rx_in_data,
  output logic [CW-1:0]    tx_level,
  output logic [CW-1:0]    rx_level,
  output logic [ST_W-1:0]  raw_status,
  output logic [ST_W-1:0]  masked_status,
  output logic             irq
);
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic flush;

  assign flush   = ~en;
  assign tx_push = en & cpu_wr;
  assign tx_pop  = en & tx_out_ready;
  assign rx_push = en & rx_in_valid;
  assign rx_pop  = en & cpu_rd;

  sfi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .push_data(cpu_wdata), .pop(tx_pop),
    .head(tx_out_data), .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sfi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .push_data(rx_in_data), .pop(rx_pop),
    .head(cpu_rdata), .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign tx_out_valid = ~tx_empty;

  // index 0 = transmit threshold, index 1 = receive threshold
  logic [1:0]       thr_we;
  logic [THR_W-1:0] thr_val [2];
  assign thr_we = {rx_thr_we, tx_thr_we};

  for (genvar g = 0; g < 2; g++) begin : g_thr
    sfi_thresh #(.DEPTH(DEPTH), .IN_W(THR_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .we(thr_we[g]),
      .wdata(thr_wdata), .value(thr_val[g])
    );
  end

  assign tx_thr = thr_val[0];
  assign rx_thr = thr_val[1];

  logic txe_lvl, rxf_lvl;
  assign txe_lvl = (32'(tx_level) <= 32'(tx_thr));
  assign rxf_lvl = (32'(rx_level) >  32'(rx_thr));

  sfi_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(sts_clr),
    .txo_evt(tx_push & tx_full),
    .rxu_evt(rx_pop & rx_empty),
    .rxo_evt(rx_push & rx_full),
    .txe_lvl(txe_lvl), .rxf_lvl(rxf_lvl),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
    .raw(raw_status), .masked(masked_status), .irq(irq)
  );
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import sfi_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THR_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic             sts_clr,
  input logic             rx_in_valid,
  input logic [CW-1:0]    tx_level,
  input logic [CW-1:0]    rx_level,
  input logic [THR_W-1:0] tx_thr,
  input logic [ST_W-1:0]  raw_status,
  input logic [ST_W-1:0]  mask_q,
  input logic             irq,
  input logic             tx_out_valid
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULLC) && (rx_level <= FULLC));

  p_txoi_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cpu_wr && tx_level == FULLC) |=> (!en || raw_status[ST_TXOI]));

  p_rxoi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_in_valid && rx_level == FULLC) |=> (!en || raw_status[ST_RXOI]));

  p_rxui_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cpu_rd && rx_level == '0) |=> (!en || raw_status[ST_RXUI]));

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(raw_status[ST_TXOI]) && !$past(sts_clr))
      |-> raw_status[ST_TXOI]);

  p_mask_silence_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  p_thr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_thr) < 32'(DEPTH));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (tx_level == '0 && rx_level == '0));

  p_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid == (tx_level != '0));
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .sts_clr(sts_clr), .rx_in_valid(rx_in_valid), .tx_level(tx_level),
  .rx_level(rx_level), .tx_thr(tx_thr), .raw_status(raw_status),
  .mask_q(mask_q), .irq(irq), .tx_out_valid(tx_out_valid)
);

// File: tb/spi_fifo_irq_unit_bench.sv
module spi_fifo_irq_unit_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int THR_W = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [WIDTH-1:0] cpu_wdata = '0, rx_in_data = '0;
  logic tx_thr_we = 1'b0, rx_thr_we = 1'b0, mask_we = 1'b0, sts_clr = 1'b0;
  logic [THR_W-1:0] thr_wdata = '0;
  logic [4:0] mask_wdata = '0;
  logic tx_out_ready = 1'b0, rx_in_valid = 1'b0;

  logic [WIDTH-1:0] cpu_rdata, tx_out_data;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [4:0] mask_q, raw_status, masked_status;
  logic tx_out_valid, irq;
  logic [CW-1:0] tx_level, rx_level;

  always #(CLK_P/2) clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .THR_W(THR_W)) u_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .tx_thr_we(tx_thr_we),
    .rx_thr_we(rx_thr_we), .thr_wdata(thr_wdata), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q), .sts_clr(sts_clr),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .tx_level(tx_level),
    .rx_level(rx_level), .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [WIDTH-1:0] txq[$];
  logic [WIDTH-1:0] rxq[$];
  bit   m_txo, m_rxu, m_rxo;
  int   m_txthr, m_rxthr;
  bit [4:0] m_mask;
  bit   started = 0;
  int   nvec = 0, nerr = 0, cycles = 0;
  int   tl, rl;
  bit   e_txo, e_rxu, e_rxo;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_txo = 0; m_rxu = 0; m_rxo = 0;
      m_txthr = 0; m_rxthr = 0; m_mask = '0;
      started = 1;
    end else begin
      if (tx_thr_we && int'(thr_wdata) < DEPTH) m_txthr = int'(thr_wdata);
      if (rx_thr_we && int'(thr_wdata) < DEPTH) m_rxthr = int'(thr_wdata);
      if (mask_we) m_mask = mask_wdata;
      if (!en) begin
        txq.delete(); rxq.delete();
        m_txo = 0; m_rxu = 0; m_rxo = 0;
      end else begin
        tl = txq.size(); rl = rxq.size();
        e_txo = cpu_wr && tl == DEPTH;
        e_rxo = rx_in_valid && rl == DEPTH;
        e_rxu = cpu_rd && rl == 0;
        if (tx_out_ready && tl > 0) void'(txq.pop_front());
        if (cpu_wr && tl < DEPTH) txq.push_back(cpu_wdata);
        if (cpu_rd && rl > 0) void'(rxq.pop_front());
        if (rx_in_valid && rl < DEPTH) rxq.push_back(rx_in_data);
        if (sts_clr) begin m_txo = 0; m_rxu = 0; m_rxo = 0; end
        m_txo = m_txo | e_txo;
        m_rxu = m_rxu | e_rxu;
        m_rxo = m_rxo | e_rxo;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [4:0] exp_raw();
    bit [4:0] r;
    r = '0;
    if (en) begin
      r[0] = txq.size() <= m_txthr;
      r[1] = m_txo;
      r[2] = m_rxu;
      r[3] = m_rxo;
      r[4] = rxq.size() > m_rxthr;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (started) begin
      bit [4:0] er;
      er = exp_raw();
      chk("R1 tx_level", int'(tx_level), txq.size());
      chk("R1 rx_level", int'(rx_level), rxq.size());
      chk("R12 tx_out_valid", int'(tx_out_valid), int'(txq.size() != 0));
      if (txq.size() > 0) chk("R2 tx_out_data", int'(tx_out_data), int'(txq[0]));
      if (rxq.size() > 0) chk("R2 cpu_rdata", int'(cpu_rdata), int'(rxq[0]));
      chk("R3 txe bit0", int'(raw_status[0]), int'(er[0]));
      chk("R5/R8 txo bit1", int'(raw_status[1]), int'(er[1]));
      chk("R7/R8 rxu bit2", int'(raw_status[2]), int'(er[2]));
      chk("R6/R8 rxo bit3", int'(raw_status[3]), int'(er[3]));
      chk("R4 rxf bit4", int'(raw_status[4]), int'(er[4]));
      if (!en) chk("R11 raw gated", int'(raw_status), 0);
      chk("R9 mask_q", int'(mask_q), int'(m_mask));
      chk("R9 masked", int'(masked_status), int'(er & m_mask));
      chk("R9 irq", int'(irq), int'(|(er & m_mask)));
      chk("R10 tx_thr", int'(tx_thr), m_txthr);
      chk("R10 rx_thr", int'(rx_thr), m_rxthr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    cpu_wr = 0; cpu_rd = 0; tx_thr_we = 0; rx_thr_we = 0;
    mask_we = 0; sts_clr = 0; tx_out_ready = 0; rx_in_valid = 0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    en = 1; tick();
    // thresholds and mask
    tx_thr_we = 1; thr_wdata = 2; tick(); quiet();
    rx_thr_we = 1; thr_wdata = 3; tick(); quiet();
    mask_we = 1; mask_wdata = 5'h1F; tick(); quiet();
    // R5: fill transmit queue and write once more
    for (int i = 0; i < DEPTH + 1; i++) begin
      cpu_wr = 1; cpu_wdata = WIDTH'(16'h100 + i); tick();
    end
    quiet();
    // R5: write to full queue while engine takes a word
    cpu_wr = 1; cpu_wdata = 16'hBEEF; tx_out_ready = 1; tick(); quiet();
    tx_out_ready = 1; repeat (DEPTH + 2) tick(); quiet();
    sts_clr = 1; tick(); quiet();
    // R6: overfill receive queue
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_in_valid = 1; rx_in_data = WIDTH'(16'h200 + i); tick();
    end
    quiet();
    // R7: drain past empty; R8: clear coincident with underflow
    cpu_rd = 1; repeat (DEPTH) tick();
    sts_clr = 1; tick(); quiet();
    tick();
    sts_clr = 1; tick(); quiet();
    // R10: depth probe
    tx_thr_we = 1; thr_wdata = 8'(DEPTH); tick(); quiet();
    rx_thr_we = 1; thr_wdata = 8'd200; tick(); quiet();
    tx_thr_we = 1; thr_wdata = 8'(DEPTH - 1); tick(); quiet();
    // R9: partial and empty masks
    mask_we = 1; mask_wdata = 5'b00010; tick(); quiet();
    cpu_wr = 1; repeat (DEPTH + 1) tick(); quiet();
    mask_we = 1; mask_wdata = 5'b00000; tick(); quiet();
    // R11: disable with pending data and flags
    rx_in_valid = 1; tick(); quiet();
    en = 0; cpu_wr = 1; rx_in_valid = 1; tick(); tick(); quiet();
    en = 1; tick();
    // random phase
    for (int n = 0; n < 6000; n++) begin
      int k;
      k = (n / 500) % 4;
      cpu_wr       = ($urandom % 4) < (k + 1);
      cpu_wdata    = WIDTH'($urandom);
      tx_out_ready = ($urandom % 4) < (4 - k);
      rx_in_valid  = ($urandom % 4) < (k + 1);
      rx_in_data   = WIDTH'($urandom);
      cpu_rd       = ($urandom % 4) < (4 - k);
      sts_clr      = ($urandom % 16) == 0;
      tx_thr_we    = ($urandom % 32) == 0;
      rx_thr_we    = ($urandom % 32) == 0;
      thr_wdata    = THR_W'($urandom % 16);
      mask_we      = ($urandom % 32) == 0;
      mask_wdata   = 5'($urandom);
      en           = ($urandom % 64) != 0;
      tick();
    end
    quiet(); en = 1; tick(); tick();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule